// File: doc/BRIEF.md
# Amplitude-Binned Timing Slew Corrector

This block trims the walk of a time-to-amplitude (TAC) measurement that depends on pulse height. Each sample carries a channel index, a 12-bit ADC amplitude and a 12-bit TAC value. These values already have pedestal and offset removed. On a timing channel, the block looks up which of eight programmable amplitude bins the ADC value falls into. It then adds that bin's signed correction to the TAC value, clamps the result to the 12-bit range and passes it on one clock later. The next stage applies channel masks.

Only channels whose index has bit 2 set are timing channels: 4–7, 12–15, 20–23 and 28–31 out of 0–31. Every other channel flows through with its TAC value untouched. A write port loads the bin limits and offsets for each timing channel. Each write names a channel, a bin and a row type. For software, bins are expected to be nondecreasing. At least one bin should be 4095, and any unused bins should sit at the top with the limit 4095.

Top module: `slew_corrector`

## Requirements
- R1: A sample presented with `inValid` high appears at the output one clock later with `outValid` high and `outChan` equal to its channel. A cycle without `inValid` gives `outValid` low on the next clock.
- R2: A channel whose index bit 2 is 0 leaves with `outTac` equal to its input TAC, whatever the table holds.
- R3: On a timing channel, the bin used is the lowest-index bin whose limit is greater than or equal to the ADC value. An ADC value of 0 therefore uses bin 0. When several bins have equal limits, the lowest index among them wins.
- R4: The chosen bin's offset is a 9-bit two's-complement value. It is sign-extended and added to the TAC value.
- R5: The corrected TAC saturates: a sum below 0 gives 0, and a sum above 4095 gives 4095.
- R6: A write with `cfgWe` high and `cfgRow` = 0 stores `cfgData[11:0]` as the limit of bin `cfgBin` of channel `cfgChan`. With `cfgRow` = 1, the write stores `cfgData[8:0]` as that bin's offset. Writes naming a channel with bit 2 clear change nothing.
- R7: After reset, `outValid` is 0, every limit is 4095 and every offset is 0, so timing channels come out uncorrected.
- R8: A table write takes effect for samples that arrive on the following cycle or later. A sample presented in the same cycle as the write uses the old entry.
- R9: If the ADC value exceeds every limit of the channel, the block uses bin 7.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Table write strobe |
| cfgChan | input | 5 | Channel addressed by the write |
| cfgBin | input | 3 | Bin addressed by the write |
| cfgRow | input | 1 | 0 = limit row, 1 = offset row |
| cfgData | input | 12 | Write data (limit 12 bits, offset low 9 bits) |
| inValid | input | 1 | Sample strobe |
| inChan | input | 5 | Sample channel index |
| inAdc | input | 12 | Sample amplitude |
| inTac | input | 12 | Sample timing value |
| outValid | output | 1 | Corrected sample strobe |
| outChan | output | 5 | Channel of the corrected sample |
| outTac | output | 12 | Corrected, saturated timing value |

## Verification
Directed patterns put the ADC value exactly on a bin limit and one count above it. This tells the inclusive upper edge apart from an exclusive one. Tables with repeated limits distinguish lowest-index from highest-index resolution, and an ADC value above all limits confirms the bin 7 fallback. TAC values near 0 and 4095, paired with large offsets of each sign, tell saturation apart from wrap-around. Randomly sorted tables with random samples on all 32 channels exercise bin selection and passthrough together, and a write in the same cycle as a sample on the same channel shows whether the old or the new entry is used.

// File: rtl/slew_pkg.sv
package slew_pkg;
  localparam int CHAN_W     = 5;
  localparam int ADC_W      = 12;
  localparam int TAC_W      = 12;
  localparam int OFS_W      = 9;
  localparam int NUM_BINS   = 8;
  localparam int TIMING_BIT = 2;
  localparam int BIN_W      = $clog2(NUM_BINS);
  localparam int SLOT_W     = CHAN_W - 1;
  localparam int NUM_SLOTS  = 2 ** SLOT_W;
  localparam int CFG_W      = (ADC_W > OFS_W) ? ADC_W : OFS_W;
  localparam int SUM_W      = TAC_W + 2;

  typedef struct packed {
    logic              wrLimit;
    logic              wrOffset;
    logic [SLOT_W-1:0] wrSlot;
    logic [BIN_W-1:0]  wrBin;
    logic              capture;
    logic              correct;
    logic [SLOT_W-1:0] rdSlot;
  } ctrlStrobes_t;

  function automatic logic isTiming(input logic [CHAN_W-1:0] ch);
    return ch[TIMING_BIT];
  endfunction

  function automatic logic [SLOT_W-1:0] slotOf(input logic [CHAN_W-1:0] ch);
    return {ch[CHAN_W-1:TIMING_BIT+1], ch[TIMING_BIT-1:0]};
  endfunction
endpackage

// File: rtl/slew_ctrl.sv
module slew_ctrl
  import slew_pkg::*;
(
  input  logic              cfgWe,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [BIN_W-1:0]  cfgBin,
  input  logic              cfgRow,
  input  logic              inValid,
  input  logic [CHAN_W-1:0] inChan,
  output ctrlStrobes_t      strobes
);
  logic cfgHit;

  always_comb begin
    cfgHit           = cfgWe && isTiming(cfgChan);
    strobes.wrLimit  = cfgHit && !cfgRow;
    strobes.wrOffset = cfgHit && cfgRow;
    strobes.wrSlot   = slotOf(cfgChan);
    strobes.wrBin    = cfgBin;
    strobes.capture  = inValid;
    strobes.correct  = inValid && isTiming(inChan);
    strobes.rdSlot   = slotOf(inChan);
  end
endmodule

// File: rtl/slew_datapath.sv
module slew_datapath
  import slew_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  ctrlStrobes_t      strobes,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic [CHAN_W-1:0] inChan,
  input  logic [ADC_W-1:0]  inAdc,
  input  logic [TAC_W-1:0]  inTac,
  output logic              outValid,
  output logic [CHAN_W-1:0] outChan,
  output logic [TAC_W-1:0]  outTac
);
  localparam logic signed [SUM_W-1:0] TAC_MAX = SUM_W'((2 ** TAC_W) - 1);

  logic [ADC_W-1:0] limitTab  [NUM_SLOTS][NUM_BINS];
  logic [OFS_W-1:0] offsetTab [NUM_SLOTS][NUM_BINS];

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    for (genvar b = 0; b < NUM_BINS; b++) begin : g_bin
      logic hitHere;
      assign hitHere = (strobes.wrSlot == SLOT_W'(s)) && (strobes.wrBin == BIN_W'(b));

      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
          limitTab[s][b]  <= '1;
          offsetTab[s][b] <= '0;
        end else begin
          if (strobes.wrLimit && hitHere)  limitTab[s][b]  <= cfgData[ADC_W-1:0];
          if (strobes.wrOffset && hitHere) offsetTab[s][b] <= cfgData[OFS_W-1:0];
        end
      end
    end
  end

  logic [NUM_BINS-1:0] geMask;
  logic [BIN_W-1:0]    selBin;
  logic                found;
  logic signed [SUM_W-1:0] sum;
  logic [TAC_W-1:0]    clamped;

  for (genvar b = 0; b < NUM_BINS; b++) begin : g_cmp
    assign geMask[b] = (limitTab[strobes.rdSlot][b] >= inAdc);
  end

  always_comb begin
    selBin = BIN_W'(NUM_BINS - 1);
    found  = 1'b0;
    for (int b = 0; b < NUM_BINS; b++) begin
      if (!found && geMask[b]) begin
        selBin = BIN_W'(b);
        found  = 1'b1;
      end
    end
  end

  always_comb begin
    sum = $signed({2'b00, inTac}) +
          {{(SUM_W-OFS_W){offsetTab[strobes.rdSlot][selBin][OFS_W-1]}},
           offsetTab[strobes.rdSlot][selBin]};
    if (sum < 0)             clamped = '0;
    else if (sum > TAC_MAX)  clamped = '1;
    else                     clamped = sum[TAC_W-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      outValid <= 1'b0;
      outChan  <= '0;
      outTac   <= '0;
    end else begin
      outValid <= strobes.capture;
      if (strobes.capture) begin
        outChan <= inChan;
        outTac  <= strobes.correct ? clamped : inTac;
      end
    end
  end
endmodule

// File: rtl/slew_corrector.sv
module slew_corrector
  import slew_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWe,
  input  logic [CHAN_W-1:0] cfgChan,
  input  logic [BIN_W-1:0]  cfgBin,
  input  logic              cfgRow,
  input  logic [CFG_W-1:0]  cfgData,
  input  logic              inValid,
  input  logic [CHAN_W-1:0] inChan,
  input  logic [ADC_W-1:0]  inAdc,
  input  logic [TAC_W-1:0]  inTac,
  output logic              outValid,
  output logic [CHAN_W-1:0] outChan,
  output logic [TAC_W-1:0]  outTac
);
  ctrlStrobes_t strobes;

  slew_ctrl u_ctrl (
    .cfgWe   (cfgWe),
    .cfgChan (cfgChan),
    .cfgBin  (cfgBin),
    .cfgRow  (cfgRow),
    .inValid (inValid),
    .inChan  (inChan),
    .strobes (strobes)
  );

  slew_datapath u_dp (
    .clk      (clk),
    .rst_n    (rst_n),
    .strobes  (strobes),
    .cfgData  (cfgData),
    .inChan   (inChan),
    .inAdc    (inAdc),
    .inTac    (inTac),
    .outValid (outValid),
    .outChan  (outChan),
    .outTac   (outTac)
  );
endmodule

// File: rtl/slew_corrector_chk.sv
module slew_corrector_chk
  import slew_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              inValid,
  input logic [CHAN_W-1:0] inChan,
  input logic [TAC_W-1:0]  inTac,
  input logic              outValid,
  input logic [CHAN_W-1:0] outChan,
  input logic [TAC_W-1:0]  outTac
);
  // R1
  valid_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> outValid);

  // R1
  valid_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inValid |=> !outValid);

  // R1
  chan_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    inValid |=> (outChan == $past(inChan)));

  // R2
  passthru_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (inValid && !isTiming(inChan)) |=> (outTac == $past(inTac)));
endmodule

bind slew_corrector slew_corrector_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .inValid  (inValid),
  .inChan   (inChan),
  .inTac    (inTac),
  .outValid (outValid),
  .outChan  (outChan),
  .outTac   (outTac)
);

// File: tb/sim_slew_corrector.sv
`timescale 1ns/1ps
module sim_slew_corrector;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfgWe = 1'b0;
  logic [4:0]  cfgChan = '0;
  logic [2:0]  cfgBin = '0;
  logic        cfgRow = 1'b0;
  logic [11:0] cfgData = '0;
  logic        inValid = 1'b0;
  logic [4:0]  inChan = '0;
  logic [11:0] inAdc = '0;
  logic [11:0] inTac = '0;
  logic        outValid;
  logic [4:0]  outChan;
  logic [11:0] outTac;

  int tests = 0;
  int fails = 0;
  bit finished = 0;

  int lim [32][8];
  int ofs [32][8];

  bit pendV = 0;
  int pendChan, pendTac;
  string pendTag;

  always #10 clk = ~clk;

  slew_corrector u0 (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgChan(cfgChan), .cfgBin(cfgBin),
    .cfgRow(cfgRow), .cfgData(cfgData), .inValid(inValid), .inChan(inChan),
    .inAdc(inAdc), .inTac(inTac), .outValid(outValid), .outChan(outChan), .outTac(outTac)
  );

  function automatic int expTac(int ch, int adc, int tac);
    int bin = 7;
    int v;
    if (((ch >> 2) & 1) == 0) return tac;
    for (int b = 7; b >= 0; b--) if (lim[ch][b] >= adc) bin = b;
    v = tac + ofs[ch][bin];
    if (v < 0) v = 0;
    if (v > 4095) v = 4095;
    return v;
  endfunction

  task automatic check(string tag, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // One cycle: check the sample driven last cycle, then drive the next inputs.
  task automatic step(bit we, int wch, int wbin, bit wrow, int wdata,
                      bit v, int ch, int adc, int tac, string tag);
    @(negedge clk);
    if (pendV) begin
      check({tag_prev(), " R1 valid"}, outValid, 1);
      check({tag_prev(), " R1 chan"}, outChan, pendChan);
      check(tag_prev(), outTac, pendTac);
    end else begin
      check("R1 idle valid", outValid, 0);
    end
    pendV = v;
    if (v) begin
      pendChan = ch;
      pendTac  = expTac(ch, adc, tac);
      pendTag  = tag;
    end
    if (we && (((wch >> 2) & 1) == 1)) begin
      if (wrow) ofs[wch][wbin] = (wdata & 9'h100) ? (wdata & 9'h1ff) - 512 : (wdata & 9'h1ff);
      else      lim[wch][wbin] = wdata & 12'hfff;
    end
    cfgWe = we; cfgChan = 5'(wch); cfgBin = 3'(wbin); cfgRow = wrow; cfgData = 12'(wdata);
    inValid = v; inChan = 5'(ch); inAdc = 12'(adc); inTac = 12'(tac);
  endtask

  function automatic string tag_prev();
    return pendTag;
  endfunction

  task automatic wr(int ch, int bin, bit row, int data);
    step(1, ch, bin, row, data, 0, 0, 0, 0, "");
  endtask

  task automatic smp(int ch, int adc, int tac, string tag);
    step(0, 0, 0, 0, 0, 1, ch, adc, tac, tag);
  endtask

  task automatic loadTable(int ch, int l[8], int o[8]);
    for (int b = 0; b < 8; b++) begin
      wr(ch, b, 0, l[b]);
      wr(ch, b, 1, o[b] & 9'h1ff);
    end
  endtask

  initial begin
    int dl[8] = '{40, 80, 120, 170, 250, 400, 700, 4095};
    int dof[8] = '{120, 70, 33, 11, -2, -19, -37, -63};
    int el[8] = '{100, 100, 100, 200, 200, 4095, 4095, 4095};
    int eo[8] = '{5, 6, 7, 8, 9, 10, 11, 12};
    int ll[8] = '{50, 50, 50, 50, 50, 50, 50, 50};
    int lo[8] = '{1, 2, 3, 4, 5, 6, 7, 9};
    void'($urandom(32'd1234));
    for (int c = 0; c < 32; c++) for (int b = 0; b < 8; b++) begin
      lim[c][b] = 4095; ofs[c][b] = 0;
    end
    repeat (3) @(negedge clk);
    check("R7 reset outValid", outValid, 0);
    rst_n = 1'b1;
    // R7: reset tables leave timing channels uncorrected
    smp(5, 0, 1234, "R7 reset table ch5");
    smp(31, 4095, 77, "R7 reset table ch31");
    // R3 R4: directed bins with limit edges
    loadTable(13, dl, dof);
    smp(13, 0, 1000, "R3 adc zero bin0");
    smp(13, 40, 1000, "R3 on limit bin0");
    smp(13, 41, 1000, "R3 above limit bin1");
    smp(13, 700, 1000, "R4 neg offset bin6");
    smp(13, 701, 1000, "R4 last bin");
    // R5 saturation
    smp(13, 4000, 20, "R5 clamp low");
    smp(13, 1, 4050, "R5 clamp high");
    // R2 passthrough and ignored writes (R6)
    wr(9, 0, 1, 200);
    wr(9, 0, 0, 0);
    smp(9, 0, 500, "R6 R2 nontiming write ignored");
    smp(3, 10, 4095, "R2 passthrough ch3");
    // R3 equal limits resolve low
    loadTable(22, el, eo);
    smp(22, 100, 2000, "R3 equal limits low index");
    smp(22, 150, 2000, "R3 equal limits second group");
    // R9 above all limits
    loadTable(6, ll, lo);
    smp(6, 51, 300, "R9 above all limits");
    // R8 same-cycle write uses old entry, next cycle new
    step(1, 6, 7, 1, 100, 1, 6, 60, 300, "R8 same cycle old");
    smp(6, 60, 300, "R8 next cycle new");
    // Random tables and samples
    for (int c = 4; c < 32; c++) begin
      if (((c >> 2) & 1) == 0) continue;
      begin
        int rl[8];
        int ro[8];
        for (int b = 0; b < 8; b++) begin
          rl[b] = $urandom_range(0, 4095);
          ro[b] = int'($urandom_range(0, 511)) - 256;
        end
        for (int i = 1; i < 8; i++) for (int j = i; j > 0 && rl[j-1] > rl[j]; j--) begin
          int t = rl[j]; rl[j] = rl[j-1]; rl[j-1] = t;
        end
        if ($urandom_range(0, 1) == 1) rl[7] = 4095;
        loadTable(c, rl, ro);
      end
    end
    for (int i = 0; i < 3000; i++) begin
      int ch = $urandom_range(0, 31);
      int adc = $urandom_range(0, 4095);
      int tac = ($urandom_range(0, 3) == 0) ? $urandom_range(0, 200) : $urandom_range(0, 4095);
      if ($urandom_range(0, 3) == 0) adc = lim[ch][$urandom_range(0, 7)] + int'($urandom_range(0, 2)) - 1;
      if (adc < 0) adc = 0;
      if (adc > 4095) adc = 4095;
      if ($urandom_range(0, 5) == 0) step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
      else smp(ch, adc, tac, "R3 R4 R5 random");
    end
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    step(0, 0, 0, 0, 0, 0, 0, 0, 0, "");
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #(20 * 150000);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule